// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It drives the channel multiplexer, the sample/hold switch and the tap selector of a resistor string, and it reads back one comparator bit per step. Software-facing bits arrive as plain level inputs: an enable that powers the analog front end, a run bit that requests conversions, a channel number and a flag that marks a high reference voltage.

After the enable rises, the block waits a settling time, counted in clock cycles. The count is shorter when the high-reference flag is set. Once the front end is settled and run is high, each conversion works the same way. A fixed-length sample phase on the captured channel comes first. A hold phase follows, during which the ten bits are decided from the most significant down. The finished code is then copied into a result register together with a single-cycle end-of-conversion pulse. Conversions follow one another with no gap for as long as run stays high. If run or enable drops, the conversion in progress is abandoned and the result register keeps its old value.

Top module: `sar_seq`

## Requirements
- R1: While reset is held and right after it, sample_o, eoc_o, trial_o and result_o are all zero, and mux_sel_o is zero.
- R2: After enable_i rises, no sample phase starts until enable_i has been high for SETTLE_CYC clock edges, or for SETTLE_HI_CYC edges when hi_ref_i is 1. With run_i already high, sample_o first reads 1 in cycle SETTLE_CYC+1 (or SETTLE_HI_CYC+1) after enable_i is applied.
- R3: A run_i that is set before the settling count ends causes no sampling until the count ends, and then starts with no further request.
- R4: When enable_i has stayed high since it settled, setting run_i starts the sample phase at the next clock edge. Clearing enable_i discards the settling, so the full wait applies again.
- R5: Each sample phase holds sample_o high for exactly SAMPLE_CYC cycles. It captures chan_i into mux_sel_o at its first edge, and mux_sel_o stays unchanged until the next sample phase begins.
- R6: trial_o is zero outside the hold phase. The first trial code is 512 (only bit 9 set). Each later trial keeps the bits already decided and sets the next lower bit. A bit stays 1 when cmp_i is 1, meaning the input is at or above the tap, and is cleared when cmp_i is 0.
- R7: The edge that decides bit 0 writes the final code into result_o and raises eoc_o. eoc_o stays high for exactly one cycle. For an input level v, the result is v.
- R8: While run_i and enable_i stay high, a new sample phase starts in the same cycle that eoc_o rises, so conversions repeat every SAMPLE_CYC+10 cycles.
- R9: Clearing run_i or enable_i during a sample or hold phase returns the block to idle at the next edge. sample_o and trial_o then read zero, no eoc_o pulse follows, and result_o is left unchanged.
- R10: result_o changes only in a cycle where eoc_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_i | input | CH_W | Requested input channel |
| enable_i | input | 1 | Analog front-end enable (starts settling) |
| hi_ref_i | input | 1 | High reference voltage, selects the shorter settling count |
| run_i | input | 1 | Conversion request, repeats while high |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the tap |
| mux_sel_o | output | CH_W | Channel captured for the current conversion |
| sample_o | output | 1 | Sample/hold switch closed (sampling) |
| trial_o | output | WIDTH | Trial code for the tap selector, zero outside the hold phase |
| result_o | output | WIDTH | Last completed conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The checker assumes that cmp_i is a function of the trial code presented in the same cycle and that the analog level does not move while bits are being decided. The bench meets this by driving cmp_i combinationally from trial_o against a held integer level, and it changes that level only outside the hold phase or in the same cycle as an abort. The checker also assumes that control inputs change only between clock edges, and every input is driven on the falling edge. Channel changes are placed in the middle of a conversion to exercise the capture rule.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_HOLD   = 2'd2
   } sar_phase_e;

endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
   parameter int unsigned NORM_CYC = 2125,
   parameter int unsigned HI_CYC   = 1750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic hi_ref_i,
   output logic ready_o
);

   localparam int unsigned MAX_CYC = (NORM_CYC > HI_CYC) ? NORM_CYC : HI_CYC;
   localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   if (NORM_CYC < 1) begin : g_bad_norm
      $error("sar_settle_timer: NORM_CYC must be at least 1");
   end
   if (HI_CYC < 1) begin : g_bad_hi
      $error("sar_settle_timer: HI_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   if (NORM_CYC == HI_CYC) begin : g_one_limit
      assign limit = CNT_W'(NORM_CYC - 1);
      logic unused_hi;
      assign unused_hi = hi_ref_i;
   end else begin : g_two_limits
      assign limit = hi_ref_i ? CNT_W'(HI_CYC - 1) : CNT_W'(NORM_CYC - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_o <= 1'b0;
      end else if (!enable_i) begin
         cnt_q   <= '0;
         ready_o <= 1'b0;
      end else if (!ready_o) begin
         if (cnt_q >= limit) begin
            ready_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int unsigned SAMPLE_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       enable_i,
   input  logic       ready_i,
   input  logic       last_i,
   output sar_phase_e phase_o,
   output logic       capture_o,
   output logic       load_o,
   output logic       step_o,
   output logic       done_o,
   output logic       clear_o
);

   localparam int unsigned CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_CYC - 1);

   if (SAMPLE_CYC < 1) begin : g_bad_sample
      $error("sar_seq_ctrl: SAMPLE_CYC must be at least 1");
   end

   sar_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q;
   logic             go;

   assign go      = run_i & enable_i;
   assign phase_o = phase_q;

   always_comb begin
      phase_d   = phase_q;
      capture_o = 1'b0;
      load_o    = 1'b0;
      step_o    = 1'b0;
      done_o    = 1'b0;
      clear_o   = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (go && ready_i) begin
               phase_d   = PH_SAMPLE;
               capture_o = 1'b1;
            end
         end
         PH_SAMPLE: begin
            if (!go) begin
               phase_d = PH_IDLE;
               clear_o = 1'b1;
            end else if (cnt_q == CNT_LAST) begin
               phase_d = PH_HOLD;
               load_o  = 1'b1;
            end
         end
         PH_HOLD: begin
            if (!go) begin
               phase_d = PH_IDLE;
               clear_o = 1'b1;
            end else begin
               step_o = 1'b1;
               if (last_i) begin
                  done_o    = 1'b1;
                  clear_o   = 1'b1;
                  capture_o = 1'b1;
                  phase_d   = PH_SAMPLE;
               end
            end
         end
         default: begin
            phase_d = PH_IDLE;
            clear_o = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (capture_o) begin
            cnt_q <= '0;
         end else if (phase_q == PH_SAMPLE) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int unsigned WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             cmp_i,
   output logic [WIDTH-1:0] trial_o,
   output logic [WIDTH-1:0] decided_o,
   output logic             last_o
);

   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   if (WIDTH < 2) begin : g_bad_width
      $error("sar_bit_engine: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] sar_q;
   logic [WIDTH-1:0] ptr_q;
   logic [WIDTH-1:0] sar_next;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign decided_o[b] = ptr_q[b] ? (sar_q[b] & cmp_i) : sar_q[b];
      if (b == WIDTH - 1) begin : g_top
         assign sar_next[b] = decided_o[b];
      end else begin : g_lower
         assign sar_next[b] = decided_o[b] | ptr_q[b+1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sar_q <= '0;
         ptr_q <= '0;
      end else if (clear_i) begin
         sar_q <= '0;
         ptr_q <= '0;
      end else if (load_i) begin
         sar_q <= TOP_BIT;
         ptr_q <= TOP_BIT;
      end else if (step_i) begin
         sar_q <= sar_next;
         ptr_q <= ptr_q >> 1;
      end
   end

   assign trial_o = sar_q;
   assign last_o  = ptr_q[0];

endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_seq_pkg::*;
#(
   parameter int unsigned WIDTH         = 10,
   parameter int unsigned CH_W          = 3,
   parameter int unsigned SETTLE_CYC    = 2125,
   parameter int unsigned SETTLE_HI_CYC = 1750,
   parameter int unsigned SAMPLE_CYC    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] chan_i,
   input  logic            enable_i,
   input  logic            hi_ref_i,
   input  logic            run_i,
   input  logic            cmp_i,
   output logic [CH_W-1:0] mux_sel_o,
   output logic            sample_o,
   output logic [WIDTH-1:0] trial_o,
   output logic [WIDTH-1:0] result_o,
   output logic            eoc_o
);

   if (CH_W < 1) begin : g_bad_ch
      $error("sar_seq: CH_W must be at least 1");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("sar_seq: WIDTH must be at least 2");
   end

   sar_phase_e       phase;
   logic             ready;
   logic             capture, load, step, done, clear, last;
   logic [WIDTH-1:0] decided;
   logic [CH_W-1:0]  chan_q;
   logic [WIDTH-1:0] result_q;
   logic             eoc_q;

   sar_settle_timer #(
      .NORM_CYC (SETTLE_CYC),
      .HI_CYC   (SETTLE_HI_CYC)
   ) i_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .hi_ref_i (hi_ref_i),
      .ready_o  (ready)
   );

   sar_seq_ctrl #(
      .SAMPLE_CYC (SAMPLE_CYC)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .enable_i  (enable_i),
      .ready_i   (ready),
      .last_i    (last),
      .phase_o   (phase),
      .capture_o (capture),
      .load_o    (load),
      .step_o    (step),
      .done_o    (done),
      .clear_o   (clear)
   );

   sar_bit_engine #(
      .WIDTH (WIDTH)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear),
      .load_i    (load),
      .step_i    (step),
      .cmp_i     (cmp_i),
      .trial_o   (trial_o),
      .decided_o (decided),
      .last_o    (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q   <= '0;
         result_q <= '0;
         eoc_q    <= 1'b0;
      end else begin
         eoc_q <= done;
         if (capture) begin
            chan_q <= chan_i;
         end
         if (done) begin
            result_q <= decided;
         end
      end
   end

   assign mux_sel_o = chan_q;
   assign sample_o  = (phase == PH_SAMPLE);
   assign result_o  = result_q;
   assign eoc_o     = eoc_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned CH_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_i,
   input logic             enable_i,
   input logic [CH_W-1:0]  mux_sel_o,
   input logic             sample_o,
   input logic [WIDTH-1:0] trial_o,
   input logic [WIDTH-1:0] result_o,
   input logic             eoc_o
);

   localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] low_set;
   assign low_set = trial_o & (~trial_o + 1'b1);

   // R2
   settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_o) |-> $past(enable_i));

   // R5
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sample_o && $past(sample_o)) || (trial_o != '0)) |-> $stable(mux_sel_o));

   // R6
   sample_no_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> (trial_o == '0));

   // R6
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sample_o) && (trial_o != '0)) |-> (trial_o == TOP_BIT));

   // R6
   trial_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(trial_o) != '0) && (trial_o != '0)) |-> (low_set == ($past(low_set) >> 1)));

   // R7
   eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |=> !eoc_o);

   // R7
   eoc_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> ($past(trial_o) != '0));

   // R9
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!sample_o && (trial_o == '0) && !eoc_o));

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_o |-> $stable(result_o));

endmodule

bind sar_seq sar_seq_chk #(
   .WIDTH (WIDTH),
   .CH_W  (CH_W)
) i_sar_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_i     (run_i),
   .enable_i  (enable_i),
   .mux_sel_o (mux_sel_o),
   .sample_o  (sample_o),
   .trial_o   (trial_o),
   .result_o  (result_o),
   .eoc_o     (eoc_o)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;

   localparam int W    = 10;
   localparam int CH_W = 3;
   localparam int ST   = 40;
   localparam int STH  = 28;
   localparam int SC   = 4;

   logic            clk    = 1'b0;
   logic            rst_n  = 1'b0;
   logic            enable = 1'b0;
   logic            run    = 1'b0;
   logic            hi_ref = 1'b0;
   logic [CH_W-1:0] chan   = '0;
   logic            cmp;
   logic [CH_W-1:0] mux_sel;
   logic            sample;
   logic [W-1:0]    trial;
   logic [W-1:0]    result;
   logic            eoc;

   int vin    = 0;
   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   assign cmp = (int'(trial) <= vin);

   sar_seq #(
      .WIDTH         (W),
      .CH_W          (CH_W),
      .SETTLE_CYC    (ST),
      .SETTLE_HI_CYC (STH),
      .SAMPLE_CYC    (SC)
   ) i_sar_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_i    (chan),
      .enable_i  (enable),
      .hi_ref_i  (hi_ref),
      .run_i     (run),
      .cmp_i     (cmp),
      .mux_sel_o (mux_sel),
      .sample_o  (sample),
      .trial_o   (trial),
      .result_o  (result),
      .eoc_o     (eoc)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 sampling, 2 deciding bits
   int m_settle, m_phase, m_cnt, m_bit, m_sar, m_res, m_ch;
   bit m_rdy, m_eoc;
   int lim, dec;
   bit rdy_before, want;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_settle = 0; m_rdy = 0; m_phase = 0; m_cnt = 0; m_bit = 0;
         m_sar = 0; m_res = 0; m_ch = 0; m_eoc = 0;
      end else begin
         lim        = hi_ref ? STH : ST;
         rdy_before = m_rdy;
         want       = run && enable;
         if (!enable) begin
            m_settle = 0; m_rdy = 0;
         end else if (!m_rdy) begin
            if (m_settle >= lim - 1) m_rdy = 1;
            else m_settle++;
         end
         m_eoc = 0;
         if (m_phase == 0) begin
            if (want && rdy_before) begin
               m_phase = 1; m_cnt = 0; m_ch = int'(chan);
            end
         end else if (!want) begin
            m_phase = 0; m_sar = 0;
         end else if (m_phase == 1) begin
            if (m_cnt == SC - 1) begin
               m_phase = 2; m_bit = W - 1; m_sar = 1 << (W - 1);
            end else m_cnt++;
         end else begin
            dec = (vin >= m_sar) ? m_sar : (m_sar & ~(1 << m_bit));
            if (m_bit == 0) begin
               m_res = dec; m_eoc = 1; m_sar = 0;
               m_phase = 1; m_cnt = 0; m_ch = int'(chan);
            end else begin
               m_bit--;
               m_sar = dec | (1 << m_bit);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5", "model sample_o",  int'(sample),  (m_phase == 1) ? 1 : 0);
         chk("R6", "model trial_o",   int'(trial),   (m_phase == 2) ? m_sar : 0);
         chk("R10", "model result_o", int'(result),  m_res);
         chk("R7", "model eoc_o",     int'(eoc),     int'(m_eoc));
         chk("R5", "model mux_sel_o", int'(mux_sel), m_ch);
      end
   end

   task automatic summary();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic until_sample(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample && n < 5000);
   endtask

   task automatic until_eoc(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!eoc && n < 5000);
   endtask

   int n;
   int seen;
   int lvls[5] = '{0, 1023, 512, 511, 1};

   initial begin
      tick(3);
      chk("R1", "sample_o in reset", int'(sample), 0);
      chk("R1", "eoc_o in reset",    int'(eoc),    0);
      rst_n = 1'b1;
      tick(2);
      chk("R1", "trial_o after reset",   int'(trial),   0);
      chk("R1", "result_o after reset",  int'(result),  0);
      chk("R1", "mux_sel_o after reset", int'(mux_sel), 0);

      // R3: run raised together with enable waits out the settling count
      vin = 700; chan = 3'd3; enable = 1'b1; run = 1'b1;
      until_sample(n);
      chk("R3", "cycles to first sample", n, ST + 1);
      chk("R5", "captured channel", int'(mux_sel), 3);
      chan = 3'd5;
      tick(SC - 1);
      chk("R5", "sample length", int'(sample), 1);
      tick(1);
      chk("R6", "first trial code", int'(trial), 512);
      tick(W - 1);
      chk("R5", "channel held mid-conversion", int'(mux_sel), 3);
      chk("R7", "no eoc before last bit", int'(eoc), 0);
      tick(1);
      chk("R7", "eoc at end", int'(eoc), 1);
      chk("R7", "result 700", int'(result), 700);
      chk("R8", "resample at eoc", int'(sample), 1);
      chk("R5", "new channel captured", int'(mux_sel), 5);

      // R8: back-to-back conversions at fixed period
      foreach (lvls[k]) begin
         vin = lvls[k];
         tick(1);
         chk("R7", "eoc one cycle", int'(eoc), 0);
         tick(SC + W - 1);
         chk("R8", "periodic eoc", int'(eoc), 1);
         chk("R7", "result level", int'(result), lvls[k]);
      end

      // R10: result kept during the next conversion
      tick(5);
      chk("R10", "result held", int'(result), 1);

      // R9: abort by run during hold
      vin = 300; run = 1'b0;
      tick(1);
      chk("R9", "sample after abort", int'(sample), 0);
      chk("R9", "trial after abort",  int'(trial),  0);
      seen = 0;
      repeat (30) begin
         @(negedge clk);
         if (eoc) seen++;
      end
      chk("R9", "eoc after abort", seen, 0);
      chk("R9", "result after abort", int'(result), 1);

      // R4: enable still set, so run starts at once
      run = 1'b1;
      until_sample(n);
      chk("R4", "direct start", n, 1);
      until_eoc(n);
      chk("R7", "result 300", int'(result), 300);

      // R9: abort by enable during hold
      tick(SC + 2);
      vin = 999; enable = 1'b0;
      tick(1);
      chk("R9", "trial after enable drop", int'(trial), 0);
      chk("R9", "result after enable drop", int'(result), 300);

      // R2 and R4: re-settle with the high reference count
      run = 1'b0;
      tick(2);
      hi_ref = 1'b1; vin = 850; enable = 1'b1; run = 1'b1;
      until_sample(n);
      chk("R2", "high-reference settle", n, STH + 1);
      chk("R4", "settle repeated after enable drop", (n > 1) ? 1 : 0, 1);
      until_eoc(n);
      chk("R7", "result 850", int'(result), 850);

      run = 1'b0;
      tick(2);
      summary();
      $finish;
   end

endmodule